// File: doc/BRIEF.md
# Indirect Register Port with Auto-Increment

This block is the processor-facing register access unit of a video controller. A host reaches a bank of 64 byte-wide configuration registers through a narrow I/O window: it first loads an index into a select register, then streams bytes through a single data port. After each data access the index can step forward on its own, so a block of registers is loaded or dumped without reloading the index. Two inhibit bits in the select register stop the stepping, one for writes and one for reads.

Each register carries a fixed access code that allows reading, writing, both or neither. Each register also carries a fixed write mask that removes unimplemented bits before they are stored. The block also keeps a small set of interrupt pending flags. Event inputs set them, the host clears them through a flag port, and one of the registers acts as their enable mask. A level interrupt output follows the enabled pending flags. A system-control port places the whole unit in a held reset state that blanks all reads to all-ones.

Top module: `vrp_regport`

## Requirements
- R1: After reset the select register, all 64 registers and the pending flags are zero and `irq` is low. A write to port offset 4 loads the full 8-bit select value, a read of offset 4 returns it, and select bits [5:0] choose the register reached through the data port at offset 3.
- R2: A data-port write steps select bits [5:0] by one, wrapping from 63 to 0, while bits [7:6] keep their values. When select bit 7 is 1 the select register does not change.
- R3: A data-port read steps select bits [5:0] by one, wrapping from 63 to 0. After the step bit 6 is 0 and bit 7 keeps its value. When select bit 6 is 1 the select register does not change.
- R4: The access code has bit 0 for read permission and bit 1 for write permission. Registers 0–5 and 32–52 are write-only, 6–27 are read/write, 53–54 are read-only, and 28–31 and 55–63 have no access. A data read of a register without read permission returns 0xFF. A data write to a register without write permission leaves its contents unchanged. The select register still steps in both cases.
- R5: Data written to a register is ANDed with that register's mask before it is stored. The masks are: register 9 → 0x87, 11 → 0x83, 12 → 0x0F, 18 → 0xDF, 19 → 0x07, 22 → 0xC1, 23 → 0x07, 24 → 0x3F, 25 → 0xCF, and every other register → 0xFF.
- R6: A 1 on bit i of `irq_evt` sets pending flag i at the next clock edge. A read of offset 6 returns the pending flags in bits [2:0] and zeros above them. `irq` is high exactly when the pending flags ANDed with bits [2:0] of register 9 are nonzero.
- R7: A write to offset 6 clears each pending flag whose data bit in [2:0] is 1. When a clear and an event hit the same flag in one cycle, the flag ends up set.
- R8: Bit 1 of a write to offset 7 sets or releases system reset. Entering it clears all 64 registers and all pending flags. While it is held, every read returns 0xFF and causes no step, writes to offsets other than 7 are ignored, and events are dropped. Select keeps its value across the reset.
- R9: Outside system reset, reads of offset 7 and of all unused offsets (0–2, 5, 8–15) return 0x00, and writes to unused offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| wr_en | input | 1 | Host write strobe for this cycle |
| rd_en | input | 1 | Host read strobe for this cycle |
| addr | input | 4 | Port offset within the I/O window |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Read data for the addressed port (combinational) |
| irq_evt | input | 3 | One-cycle event pulses, one per pending flag |
| irq | output | 1 | Level interrupt request |

## Verification
Two things can land on the pending flags in the same cycle: a host write to the flag port that clears a flag, and an event pulse that sets the same flag. The bench provokes this on purpose by putting an event on the very cycle of a clear write to the same bit. It then judges the result by reading the flag port and watching `irq`, and expects the flag to stay set. The random phase mixes sparse events with flag-port writes, so the collision occurs again under varied enable masks. A model compares every read and the interrupt level against it.

// File: rtl/vrp_pkg.sv
package vrp_pkg;

    localparam int IDX_W  = 6;
    localparam int NREG   = 1 << IDX_W;
    localparam int REG_W  = 8;
    localparam int PORT_W = 4;

    localparam logic [PORT_W-1:0] PORT_DATA = 4'd3;
    localparam logic [PORT_W-1:0] PORT_SEL  = 4'd4;
    localparam logic [PORT_W-1:0] PORT_FLAG = 4'd6;
    localparam logic [PORT_W-1:0] PORT_SYS  = 4'd7;

    localparam int SEL_NO_WR_STEP = 7;
    localparam int SEL_NO_RD_STEP = 6;
    localparam int SYS_RST_BIT    = 1;

    // access code: bit 0 = may read, bit 1 = may write
    function automatic logic [1:0] acc_code(input int idx);
        if (idx <= 5)       return 2'b10;
        else if (idx <= 27) return 2'b11;
        else if (idx <= 31) return 2'b00;
        else if (idx <= 52) return 2'b10;
        else if (idx <= 54) return 2'b01;
        else                return 2'b00;
    endfunction

    function automatic logic [REG_W-1:0] wr_mask(input int idx);
        case (idx)
            9:       return 8'h87;
            11:      return 8'h83;
            12:      return 8'h0F;
            18:      return 8'hDF;
            19:      return 8'h07;
            22:      return 8'hC1;
            23:      return 8'h07;
            24:      return 8'h3F;
            25:      return 8'hCF;
            default: return 8'hFF;
        endcase
    endfunction

endpackage

// File: rtl/vrp_select.sv
module vrp_select
    import vrp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [REG_W-1:0] load_val,
    input  logic             step_wr,
    input  logic             step_rd,
    output logic [REG_W-1:0] sel_q
);
    typedef struct packed {
        logic [REG_W-1:0] sel;
    } sel_st_t;

    sel_st_t st_d, st_q;
    logic [IDX_W-1:0] nxt_idx;

    assign nxt_idx = st_q.sel[IDX_W-1:0] + IDX_W'(1);

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.sel = load_val;
        end else if (step_wr) begin
            if (!st_q.sel[SEL_NO_WR_STEP])
                st_d.sel = {st_q.sel[REG_W-1:IDX_W], nxt_idx};
        end else if (step_rd) begin
            if (!st_q.sel[SEL_NO_RD_STEP])
                st_d.sel = {st_q.sel[SEL_NO_WR_STEP], 1'b0, nxt_idx};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sel_q = st_q.sel;
endmodule

// File: rtl/vrp_regfile.sv
module vrp_regfile
    import vrp_pkg::*;
#(
    parameter int EN_IDX = 9,
    parameter int IRQ_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  logic [REG_W-1:0] wdata,
    output logic             rd_ok,
    output logic [REG_W-1:0] rd_val,
    output logic [IRQ_W-1:0] en_val
);
    logic [NREG-1:0][REG_W-1:0] ent_d, ent_q;
    logic [NREG-1:0]            rd_perm;

    for (genvar g = 0; g < NREG; g++) begin : g_ent
        localparam logic [1:0]       AC = acc_code(g);
        localparam logic [REG_W-1:0] MK = wr_mask(g);

        assign rd_perm[g] = AC[0];

        always_comb begin
            ent_d[g] = ent_q[g];
            if (clr)
                ent_d[g] = '0;
            else if (AC[1] && we && (idx == IDX_W'(g)))
                ent_d[g] = wdata & MK;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ent_q[g] <= '0;
            else        ent_q[g] <= ent_d[g];
        end
    end

    assign rd_ok  = rd_perm[idx];
    assign rd_val = ent_q[idx];
    assign en_val = ent_q[EN_IDX][IRQ_W-1:0];
endmodule

// File: rtl/vrp_irq.sv
module vrp_irq #(
    parameter int IRQ_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             clr_we,
    input  logic [IRQ_W-1:0] clr_bits,
    input  logic [IRQ_W-1:0] evt,
    input  logic [IRQ_W-1:0] en,
    output logic [IRQ_W-1:0] pend_q,
    output logic             irq
);
    typedef struct packed {
        logic [IRQ_W-1:0] pend;
    } irq_st_t;

    irq_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d.pend = '0;
        end else begin
            if (clr_we) st_d.pend = st_d.pend & ~clr_bits;
            st_d.pend = st_d.pend | evt;   // an event outranks a clear
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_q = st_q.pend;
    assign irq    = |(st_q.pend & en);
endmodule

// File: rtl/vrp_regport.sv
module vrp_regport
    import vrp_pkg::*;
#(
    parameter int IRQ_W  = 3,
    parameter int EN_IDX = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [PORT_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    input  logic [IRQ_W-1:0]  irq_evt,
    output logic              irq
);
    typedef struct packed {
        logic sysrst;
    } top_st_t;

    top_st_t st_d, st_q;

    logic             data_wr, data_rd, sel_wr, flag_wr, sys_wr;
    logic [REG_W-1:0] sel_q;
    logic             rd_ok;
    logic [REG_W-1:0] rd_val;
    logic [IRQ_W-1:0] en_q, pend_q, evt_g;
    logic             sysrst_q;

    assign sysrst_q = st_q.sysrst;
    assign sys_wr   = wr_en && (addr == PORT_SYS);
    assign data_wr  = wr_en && (addr == PORT_DATA) && !sysrst_q;
    assign data_rd  = rd_en && (addr == PORT_DATA) && !sysrst_q;
    assign sel_wr   = wr_en && (addr == PORT_SEL)  && !sysrst_q;
    assign flag_wr  = wr_en && (addr == PORT_FLAG) && !sysrst_q;
    assign evt_g    = irq_evt;

    always_comb begin
        st_d = st_q;
        if (sys_wr) st_d.sysrst = wdata[SYS_RST_BIT];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    vrp_select u_sel (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (sel_wr),
        .load_val (wdata),
        .step_wr  (data_wr),
        .step_rd  (data_rd),
        .sel_q    (sel_q)
    );

    vrp_regfile #(.EN_IDX(EN_IDX), .IRQ_W(IRQ_W)) u_rf (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (st_d.sysrst),
        .we     (data_wr),
        .idx    (sel_q[IDX_W-1:0]),
        .wdata  (wdata),
        .rd_ok  (rd_ok),
        .rd_val (rd_val),
        .en_val (en_q)
    );

    vrp_irq #(.IRQ_W(IRQ_W)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (st_d.sysrst),
        .clr_we   (flag_wr),
        .clr_bits (wdata[IRQ_W-1:0]),
        .evt      (evt_g),
        .en       (en_q),
        .pend_q   (pend_q),
        .irq      (irq)
    );

    always_comb begin
        rdata = '0;
        if (sysrst_q) begin
            rdata = '1;
        end else begin
            case (addr)
                PORT_DATA: rdata = rd_ok ? rd_val : '1;
                PORT_SEL:  rdata = sel_q;
                PORT_FLAG: rdata = REG_W'(pend_q);
                default:   rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/vrp_regport_chk.sv
module vrp_regport_chk
    import vrp_pkg::*;
#(
    parameter int IRQ_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic [PORT_W-1:0] addr,
    input logic [REG_W-1:0]  wdata,
    input logic [REG_W-1:0]  rdata,
    input logic [IRQ_W-1:0]  irq_evt,
    input logic [REG_W-1:0]  sel_q,
    input logic [IRQ_W-1:0]  pend_q,
    input logic [IRQ_W-1:0]  en_q,
    input logic              sysrst_q
);
    a_r2_write_step: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == PORT_DATA && !sysrst_q && !sel_q[7]) |=>
        (sel_q[5:0] == $past(sel_q[5:0]) + 6'd1 && sel_q[7:6] == $past(sel_q[7:6])));

    a_r2_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == PORT_DATA && !sysrst_q && sel_q[7]) |=> $stable(sel_q));

    a_r3_read_step: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == PORT_DATA && !sysrst_q && !sel_q[6]) |=>
        (sel_q[5:0] == $past(sel_q[5:0]) + 6'd1 && !sel_q[6] && sel_q[7] == $past(sel_q[7])));

    a_r6_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
        ((|irq_evt) && !sysrst_q && !(wr_en && addr == PORT_SYS && wdata[1])) |=>
        ((pend_q & $past(irq_evt)) == $past(irq_evt)));

    a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == PORT_FLAG && !sysrst_q) |=>
        ((pend_q & $past(wdata[IRQ_W-1:0] & ~irq_evt)) == '0));

    a_r8_entry_clears: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sysrst_q) |-> (pend_q == '0 && en_q == '0));

    a_r8_read_blank: assert property (@(posedge clk) disable iff (!rst_n)
        sysrst_q |-> (rdata == 8'hFF));
endmodule

bind vrp_regport vrp_regport_chk #(.IRQ_W(IRQ_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .addr     (addr),
    .wdata    (wdata),
    .rdata    (rdata),
    .irq_evt  (irq_evt),
    .sel_q    (sel_q),
    .pend_q   (pend_q),
    .en_q     (en_q),
    .sysrst_q (sysrst_q)
);

// File: tb/tb_vrp_regport.sv
module tb_vrp_regport;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [3:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [2:0] irq_evt = '0;
    logic       irq;

    always #(CLK_P/2) clk = ~clk;

    vrp_regport dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq_evt(irq_evt), .irq(irq)
    );

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [7:0] m_reg [64];
    logic [7:0] m_sel;
    logic [2:0] m_pend;
    logic       m_srst;

    // R4 access layout: bit0 read, bit1 write
    function automatic logic [1:0] m_acc(input int i);
        if (i < 6)  return 2'b10;
        if (i < 28) return 2'b11;
        if (i < 32) return 2'b00;
        if (i < 53) return 2'b10;
        if (i < 55) return 2'b01;
        return 2'b00;
    endfunction

    // R5 write masks
    function automatic logic [7:0] m_mask(input int i);
        if (i == 9)  return 8'h87;
        if (i == 11) return 8'h83;
        if (i == 12) return 8'h0F;
        if (i == 18) return 8'hDF;
        if (i == 19) return 8'h07;
        if (i == 22) return 8'hC1;
        if (i == 23) return 8'h07;
        if (i == 24) return 8'h3F;
        if (i == 25) return 8'hCF;
        return 8'hFF;
    endfunction

    function automatic logic [7:0] m_read(input logic [3:0] a);
        logic [1:0] ac;
        if (m_srst) return 8'hFF;
        case (a)
            4'd3: begin
                ac = m_acc(int'(m_sel[5:0]));
                return ac[0] ? m_reg[m_sel[5:0]] : 8'hFF;
            end
            4'd4: return m_sel;
            4'd6: return {5'b0, m_pend};
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic m_irq();
        return |(m_pend & m_reg[9][2:0]);
    endfunction

    task automatic m_step(input logic w, input logic r, input logic [3:0] a,
                          input logic [7:0] d, input logic [2:0] e);
        logic       nr;
        logic [1:0] ac;
        nr = (w && a == 4'd7) ? d[1] : m_srst;
        if (!m_srst) begin
            if (w && a == 4'd3) begin
                ac = m_acc(int'(m_sel[5:0]));
                if (ac[1]) m_reg[m_sel[5:0]] = d & m_mask(int'(m_sel[5:0]));
                if (!m_sel[7]) m_sel = {m_sel[7:6], m_sel[5:0] + 6'd1};
            end else if (r && a == 4'd3) begin
                if (!m_sel[6]) m_sel = {m_sel[7], 1'b0, m_sel[5:0] + 6'd1};
            end
            if (w && a == 4'd4) m_sel = d;
        end
        if (nr) begin
            for (int i = 0; i < 64; i++) m_reg[i] = 8'h00;
            m_pend = 3'b000;
        end else begin
            if (!m_srst && w && a == 4'd6) m_pend = m_pend & ~d[2:0];
            m_pend = m_pend | e;
        end
        m_srst = nr;
    endtask

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic w, input logic r, input logic [3:0] a,
                       input logic [7:0] d, input logic [2:0] e, input string tag);
        @(negedge clk);
        wr_en = w; rd_en = r; addr = a; wdata = d; irq_evt = e;
        #1;
        if (r) check(tag, rdata, m_read(a));
        check({tag, " R6 irq level"}, {7'b0, irq}, {7'b0, m_irq()});
        @(posedge clk);
        m_step(w, r, a, d, e);
        #1;
        wr_en = 1'b0; rd_en = 1'b0; irq_evt = '0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d, input string tag);
        cyc(1'b1, 1'b0, a, d, 3'b000, tag);
    endtask

    task automatic rd(input logic [3:0] a, input string tag);
        cyc(1'b0, 1'b1, a, 8'h00, 3'b000, tag);
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        int         op;
        for (int i = 0; i < 64; i++) m_reg[i] = 8'h00;
        m_sel = 8'h00; m_pend = 3'b000; m_srst = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1 reset state
        rd(4'd4, "R1 reset select");
        rd(4'd6, "R1 reset flags");
        rd(4'd3, "R1 reset reg0 unreadable");
        // R1 select load
        wr(4'd4, 8'h06, "R1 select load");
        rd(4'd4, "R1 select readback");
        // R2 write burst with step
        wr(4'd3, 8'h11, "R2 burst");
        wr(4'd3, 8'h22, "R2 burst");
        wr(4'd3, 8'h33, "R2 burst");
        rd(4'd4, "R2 select after burst");
        // R3 read burst with step
        wr(4'd4, 8'h06, "R3 select load");
        rd(4'd3, "R3 burst read");
        rd(4'd3, "R3 burst read");
        rd(4'd3, "R3 burst read");
        rd(4'd4, "R3 select after reads");
        // R2 write inhibit
        wr(4'd4, 8'h8A, "R2 inhibit load");
        wr(4'd3, 8'h44, "R2 inhibited");
        wr(4'd3, 8'h45, "R2 inhibited");
        rd(4'd4, "R2 select held");
        rd(4'd3, "R3 read steps keeping bit7");
        rd(4'd4, "R3 select bit7 kept");
        // R3 read inhibit
        wr(4'd4, 8'h4A, "R3 inhibit load");
        rd(4'd3, "R3 inhibited read");
        rd(4'd3, "R3 inhibited read");
        rd(4'd4, "R3 select held");
        // R3 wrap clears bit 6 carry
        wr(4'd4, 8'hBF, "R3 wrap load");
        rd(4'd3, "R4 reg63 no access");
        rd(4'd4, "R3 wrap to 0x80");
        // R2 wrap keeps bits 7:6
        wr(4'd4, 8'h7F, "R2 wrap load");
        wr(4'd3, 8'h99, "R2 wrap write");
        rd(4'd4, "R2 wrap to 0x40");
        // R4 access rights
        wr(4'd4, 8'h00, "R4 sel");
        wr(4'd3, 8'h5A, "R4 write-only write");
        wr(4'd4, 8'h00, "R4 sel");
        rd(4'd3, "R4 write-only reads FF");
        wr(4'd4, 8'd53, "R4 sel");
        wr(4'd3, 8'h77, "R4 read-only write ignored");
        wr(4'd4, 8'd53, "R4 sel");
        rd(4'd3, "R4 read-only unchanged");
        wr(4'd4, 8'd30, "R4 sel");
        rd(4'd3, "R4 no-access reads FF");
        // R5 masks
        foreach (m_reg[i]) begin
            if (i == 9 || i == 11 || i == 12 || i == 18 || i == 19 ||
                i == 22 || i == 23 || i == 24 || i == 25 || i == 20) begin
                wr(4'd4, 8'(i), "R5 sel");
                wr(4'd3, 8'hFF, "R5 write ones");
                wr(4'd4, 8'(i), "R5 sel");
                rd(4'd3, "R5 masked readback");
            end
        end
        // R6 event and interrupt (enable now 3'b111)
        cyc(1'b0, 1'b0, 4'd0, 8'h00, 3'b010, "R6 event");
        rd(4'd6, "R6 flags after event");
        // R7 clear, then collision
        wr(4'd6, 8'h02, "R7 clear");
        rd(4'd6, "R7 flags cleared");
        cyc(1'b1, 1'b0, 4'd6, 8'h01, 3'b001, "R7 clear with event");
        rd(4'd6, "R7 event wins");
        wr(4'd6, 8'hFF, "R7 clear all");
        rd(4'd6, "R7 all clear");
        // R6 enable masking
        wr(4'd4, 8'd9, "R6 sel enable");
        wr(4'd3, 8'h01, "R6 enable bit0 only");
        cyc(1'b0, 1'b0, 4'd0, 8'h00, 3'b100, "R6 masked event");
        rd(4'd6, "R6 pending but masked");
        // R8 system reset
        wr(4'd7, 8'h02, "R8 enter");
        rd(4'd4, "R8 blank select");
        rd(4'd3, "R8 blank data");
        wr(4'd4, 8'h15, "R8 ignored select write");
        cyc(1'b0, 1'b0, 4'd0, 8'h00, 3'b111, "R8 dropped event");
        wr(4'd7, 8'h00, "R8 release");
        rd(4'd4, "R8 select kept");
        rd(4'd6, "R8 flags cleared");
        wr(4'd4, 8'd9, "R8 sel");
        rd(4'd3, "R8 register cleared");
        // R9 unused offsets
        wr(4'd5, 8'hAA, "R9 unused write");
        rd(4'd5, "R9 unused read");
        rd(4'd0, "R9 offset0 read");
        rd(4'd7, "R9 sysctrl read");
        rd(4'd4, "R9 select unchanged");

        // random phase
        void'($urandom(32'h5EED_0042));
        for (int n = 0; n < 4000; n++) begin
            logic [2:0] e;
            op = $urandom_range(0, 15);
            d  = 8'($urandom);
            e  = ($urandom_range(0, 7) == 0) ? 3'($urandom) : 3'b000;
            case (op)
                0, 1, 2, 3, 4: cyc(1'b1, 1'b0, 4'd3, d, e, "R2 R5 rand write");
                5, 6, 7, 8:    cyc(1'b0, 1'b1, 4'd3, d, e, "R3 R4 rand read");
                9, 10: begin
                    d[7:6] = ($urandom_range(0, 1) == 0) ? 2'b00 : d[7:6];
                    cyc(1'b1, 1'b0, 4'd4, d, e, "R1 rand select");
                end
                11: cyc(1'b0, 1'b1, 4'd4, d, e, "R1 rand select read");
                12: cyc(1'b0, 1'b1, 4'd6, d, e, "R6 rand flag read");
                13: cyc(1'b1, 1'b0, 4'd6, d, e, "R7 rand clear");
                14: begin
                    d[1] = m_srst ? ($urandom_range(0, 3) == 0) : ($urandom_range(0, 15) == 0);
                    cyc(1'b1, 1'b0, 4'd7, d, e, "R8 rand sysctrl");
                end
                default: cyc(1'b0, 1'b1, 4'($urandom), d, e, "R9 rand any read");
            endcase
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule